// File: doc/BRIEF.md
# Sixteen-bit Multiply/Divide Unit on a Register Pair

This unit carries out unsigned multiplication and division for a processor whose accumulator is a pair of 16-bit registers: Y holds the high half and A holds the low half. The multiply forms the full 32-bit product of A and a 16-bit source operand. It then returns the upper half for Y and the lower half for A. The divide treats Y:A as a 32-bit dividend and divides it by the source. The quotient goes back in A and the remainder in Y.

The caller presents the operands with a one-cycle `start` and an operation select. It then waits for the single-cycle `done` pulse. At that pulse the result pair and the flag outputs are valid, and the caller writes them back. A multiply runs a 16-step shift-add loop. A divide runs a 32-step restoring shift-subtract loop. Each loop is followed by one completion cycle. A zero divisor skips the loop. In that case the unit completes on the next cycle with the error and break indications raised, so that the surrounding processor can halt.

Top module: `muldiv_pair`

## Requirements
- R1: A multiply (op_div = 0) returns bits 31..16 of the unsigned product a_in × src_in on y_out and bits 15..0 on a_out.
- R2: When a multiply completes, flag_we is high. carry_out and ovf_out are then both 1 if the upper 16 bits of the product are nonzero, and both 0 otherwise.
- R3: A completing multiply raises neither err_out nor brk_out. The unit has no zero or sign output, so the multiply leaves those flags to the caller unchanged.
- R4: A divide (op_div = 1) with a nonzero source treats {y_in, a_in} as an unsigned dividend. It returns the remainder on y_out and the quotient on a_out.
- R5: A completing divide keeps flag_we low and leaves carry_out and ovf_out at their previous values.
- R6: A divide whose source is zero completes on the cycle after start, without raising busy, with done, err_out and brk_out all high for that cycle.
- R7: After a divide by zero, y_out and a_out equal the y_in and a_in presented with that start, so the pair written back is unchanged.
- R8: A quotient wider than 16 bits is truncated to its low 16 bits on a_out and raises no error.
- R9: A start seen while busy is high is ignored: neither the running operation's result nor its timing changes.
- R10: After an accepted start, busy is high for 17 cycles (multiply) or 33 cycles (divide). done then pulses for exactly one cycle with busy low, and a start in that cycle is accepted.
- R11: After reset, busy, done, flag_we, err_out, brk_out, carry_out, ovf_out, y_out and a_out are all 0.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request an operation this cycle |
| op_div | input | 1 | 0 = multiply, 1 = divide |
| y_in | input | 16 | High register of the pair |
| a_in | input | 16 | Low register of the pair |
| src_in | input | 16 | Multiplier or divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| y_out | output | 16 | Result for Y (product high or remainder) |
| a_out | output | 16 | Result for A (product low or quotient) |
| flag_we | output | 1 | Carry and overflow updated this completion |
| carry_out | output | 1 | Carry flag value |
| ovf_out | output | 1 | Overflow flag value |
| err_out | output | 1 | Divide-by-zero error, valid with done |
| brk_out | output | 1 | Break request, valid with done |

## Verification
Two events can fall on the same clock edge. In the first, the completion of one operation meets the acceptance of the next. In the second, a stray start arrives while busy is still high. The bench provokes the first by raising start in the very cycle done is seen. It provokes the second by holding start with different operands during a run. A cycle-accurate behavioural model, fed the same inputs, judges both every clock. The result of the running operation must not change, busy must not stretch, and the back-to-back operation must complete exactly one full latency after the done pulse that admitted it.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
   typedef enum logic {
      OP_MUL = 1'b0,
      OP_DIV = 1'b1
   } md_op_e;
endpackage

// File: rtl/muldiv_mul_engine.sv
module muldiv_mul_engine #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         step,
   input  logic [W-1:0] a_in,
   input  logic [W-1:0] src_in,
   output logic [W-1:0] prod_hi,
   output logic [W-1:0] prod_lo
);
   logic [W-1:0] mcand_q;
   logic [W-1:0] hi_q;
   logic [W-1:0] lo_q;
   logic [W:0]   sum;

   // add the multiplicand into the high half when the current multiplier bit is set
   assign sum = {1'b0, hi_q} + (lo_q[0] ? {1'b0, mcand_q} : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcand_q <= '0;
         hi_q    <= '0;
         lo_q    <= '0;
      end else if (load) begin
         mcand_q <= src_in;
         hi_q    <= '0;
         lo_q    <= a_in;
      end else if (step) begin
         hi_q <= sum[W:1];
         lo_q <= {sum[0], lo_q[W-1:1]};
      end
   end

   assign prod_hi = hi_q;
   assign prod_lo = lo_q;
endmodule

// File: rtl/muldiv_div_engine.sv
module muldiv_div_engine #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         step,
   input  logic [W-1:0] y_in,
   input  logic [W-1:0] a_in,
   input  logic [W-1:0] src_in,
   output logic [W-1:0] quo,
   output logic [W-1:0] rem
);
   localparam int DW = 2 * W;

   logic [DW-1:0] q_q;
   logic [W-1:0]  r_q;
   logic [W-1:0]  d_q;
   logic [W:0]    shifted;
   logic [W:0]    diff;
   logic [W:0]    nxt;
   logic          fits;

   assign shifted = {r_q, q_q[DW-1]};
   assign fits    = shifted >= {1'b0, d_q};
   assign diff    = shifted - {1'b0, d_q};
   assign nxt     = fits ? diff : shifted;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_q <= '0;
         r_q <= '0;
         d_q <= '0;
      end else if (load) begin
         q_q <= {y_in, a_in};
         r_q <= '0;
         d_q <= src_in;
      end else if (step) begin
         r_q <= nxt[W-1:0];
         q_q <= {q_q[DW-2:0], fits};
      end
   end

   assign quo = q_q[W-1:0];
   assign rem = r_q;

   // restoring invariant: partial remainder stays below the divisor
   a_r4_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
      (d_q != '0) |-> (r_q < d_q));
   a_r4_partial_fits_width: assert property (@(posedge clk) disable iff (!rst_n)
      (step && d_q != '0) |-> !nxt[W]);
endmodule

// File: rtl/muldiv_pair.sv
module muldiv_pair
   import muldiv_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         op_div,
   input  logic [W-1:0] y_in,
   input  logic [W-1:0] a_in,
   input  logic [W-1:0] src_in,
   output logic         busy,
   output logic         done,
   output logic [W-1:0] y_out,
   output logic [W-1:0] a_out,
   output logic         flag_we,
   output logic         carry_out,
   output logic         ovf_out,
   output logic         err_out,
   output logic         brk_out
);
   localparam int DW = 2 * W;
   localparam int CW = $clog2(DW + 1);
   localparam logic [CW-1:0] MUL_STEPS = CW'(W);
   localparam logic [CW-1:0] DIV_STEPS = CW'(DW);

   if (W < 2 || W > 64) begin : g_width_check
      $error("muldiv_pair: W must lie in 2..64");
   end

   md_op_e        op_q;
   logic          busy_q, done_q, fwe_q, err_q, cf_q, of_q;
   logic [CW-1:0] cnt_q;
   logic [W-1:0]  y_q, a_q;
   logic          accept, zero_div, load, step, finish;
   logic [CW-1:0] last_cnt;
   logic [W-1:0]  mul_hi, mul_lo, div_q, div_r;

   assign accept   = start && !busy_q;
   assign zero_div = op_div && (src_in == '0);
   assign load     = accept && !zero_div;
   assign last_cnt = (op_q == OP_DIV) ? DIV_STEPS : MUL_STEPS;
   assign step     = busy_q && (cnt_q != last_cnt);
   assign finish   = busy_q && (cnt_q == last_cnt);

   muldiv_mul_engine #(.W(W)) u_mul (
      .clk(clk), .rst_n(rst_n), .load(load), .step(step && op_q == OP_MUL),
      .a_in(a_in), .src_in(src_in), .prod_hi(mul_hi), .prod_lo(mul_lo)
   );

   muldiv_div_engine #(.W(W)) u_div (
      .clk(clk), .rst_n(rst_n), .load(load), .step(step && op_q == OP_DIV),
      .y_in(y_in), .a_in(a_in), .src_in(src_in), .quo(div_q), .rem(div_r)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= OP_MUL;
         busy_q <= 1'b0;
         done_q <= 1'b0;
         fwe_q  <= 1'b0;
         err_q  <= 1'b0;
         cf_q   <= 1'b0;
         of_q   <= 1'b0;
         cnt_q  <= '0;
         y_q    <= '0;
         a_q    <= '0;
      end else begin
         done_q <= 1'b0;
         fwe_q  <= 1'b0;
         err_q  <= 1'b0;
         if (accept) begin
            op_q  <= op_div ? OP_DIV : OP_MUL;
            cnt_q <= '0;
            if (zero_div) begin
               done_q <= 1'b1;
               err_q  <= 1'b1;
               y_q    <= y_in;
               a_q    <= a_in;
            end else begin
               busy_q <= 1'b1;
            end
         end else if (finish) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            if (op_q == OP_MUL) begin
               y_q   <= mul_hi;
               a_q   <= mul_lo;
               cf_q  <= |mul_hi;
               of_q  <= |mul_hi;
               fwe_q <= 1'b1;
            end else begin
               y_q <= div_r;
               a_q <= div_q;
            end
         end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign busy      = busy_q;
   assign done      = done_q;
   assign y_out     = y_q;
   assign a_out     = a_q;
   assign flag_we   = fwe_q;
   assign carry_out = cf_q;
   assign ovf_out   = of_q;
   assign err_out   = err_q;
   assign brk_out   = err_q;

   a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   a_r9_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (busy || done));
   a_r2_flags_track_high: assert property (@(posedge clk) disable iff (!rst_n)
      flag_we |-> (done && carry_out == (y_out != '0) && ovf_out == carry_out));
   a_r5_div_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !flag_we) |-> ($stable(carry_out) && $stable(ovf_out)));
   a_r6_zero_div_fast: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && op_div && src_in == '0) |=> (done && err_out && brk_out && !busy));
   a_r7_pair_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && op_div && src_in == '0) |=> (y_out == $past(y_in) && a_out == $past(a_in)));
   a_r3_mul_no_break: assert property (@(posedge clk) disable iff (!rst_n)
      flag_we |-> (!brk_out && !err_out));
endmodule

// File: tb/muldiv_pair_bench.sv
`timescale 1ns/1ps
module muldiv_pair_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        op_div = 1'b0;
   logic [15:0] y_in = '0, a_in = '0, src_in = '0;
   logic        busy, done, flag_we, carry_out, ovf_out, err_out, brk_out;
   logic [15:0] y_out, a_out;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit run_chk = 1'b0;
   string cur_tag = "R1";

   always #2.5 clk = ~clk;

   muldiv_pair u_muldiv_pair (
      .clk(clk), .rst_n(rst_n), .start(start), .op_div(op_div),
      .y_in(y_in), .a_in(a_in), .src_in(src_in),
      .busy(busy), .done(done), .y_out(y_out), .a_out(a_out),
      .flag_we(flag_we), .carry_out(carry_out), .ovf_out(ovf_out),
      .err_out(err_out), .brk_out(brk_out)
   );

   // behavioural reference model
   bit          m_busy, m_done, m_fwe, m_err, m_cf, m_of, m_op;
   int          m_left;
   logic [15:0] m_y, m_a, m_ry, m_ra;
   string       m_tag = "R11", m_ptag = "R1", m_ftag = "R2", m_etag = "R6";

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_fwe = 0; m_err = 0; m_cf = 0; m_of = 0;
         m_left = 0; m_y = 0; m_a = 0; m_op = 0;
      end else begin
         m_done = 0; m_fwe = 0; m_err = 0;
         if (m_busy) begin
            m_left = m_left - 1;
            if (m_left == 0) begin
               m_busy = 0; m_done = 1; m_y = m_ry; m_a = m_ra; m_tag = m_ptag;
               if (!m_op) begin
                  m_fwe = 1; m_cf = (m_ry != 0); m_of = m_cf;
                  m_ftag = "R2"; m_etag = "R3";
               end else begin
                  m_ftag = "R5"; m_etag = "R6";
               end
            end
         end else if (start) begin
            m_op = op_div;
            m_ptag = cur_tag;
            if (op_div && src_in == 0) begin
               m_done = 1; m_err = 1; m_y = y_in; m_a = a_in;
               m_tag = "R7"; m_ftag = "R5"; m_etag = "R6";
            end else if (!op_div) begin
               logic [31:0] p;
               p = {16'h0, a_in} * {16'h0, src_in};
               m_ry = p[31:16]; m_ra = p[15:0];
               m_busy = 1; m_left = 17;
            end else begin
               longint unsigned dvd, q, r;
               dvd = {32'h0, y_in, a_in};
               q = dvd / src_in;
               r = dvd % src_in;
               m_ra = q[15:0]; m_ry = r[15:0];
               m_busy = 1; m_left = 33;
            end
         end
      end
   end

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && run_chk) begin
         chk("R10", "busy", 32'(busy), 32'(m_busy));
         chk("R10", "done", 32'(done), 32'(m_done));
         chk(m_tag, "y_out", 32'(y_out), 32'(m_y));
         chk(m_tag, "a_out", 32'(a_out), 32'(m_a));
         chk(m_ftag, "flag_we", 32'(flag_we), 32'(m_fwe));
         chk(m_ftag, "carry", 32'(carry_out), 32'(m_cf));
         chk(m_ftag, "ovf", 32'(ovf_out), 32'(m_of));
         chk(m_etag, "err", 32'(err_out), 32'(m_err));
         chk(m_etag, "brk", 32'(brk_out), 32'(m_err));
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic issue(input bit dv, input logic [15:0] y, input logic [15:0] a,
                        input logic [15:0] s, input string tag);
      @(negedge clk);
      start = 1; op_div = dv; y_in = y; a_in = a; src_in = s; cur_tag = tag;
      @(negedge clk);
      start = 0;
   endtask

   task automatic wait_idle();
      while (m_busy) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      logic [31:0] rs;
      rs = 32'h1234_5678;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R11: reset state
      chk("R11", "busy", 32'(busy), 0);
      chk("R11", "done", 32'(done), 0);
      chk("R11", "y_out", 32'(y_out), 0);
      chk("R11", "a_out", 32'(a_out), 0);
      chk("R11", "flags", 32'({carry_out, ovf_out, flag_we, err_out, brk_out}), 0);
      run_chk = 1;

      issue(0, 16'h0000, 16'd3, 16'd5, "R1");          wait_idle();
      issue(0, 16'h0000, 16'hFFFF, 16'hFFFF, "R1");    wait_idle();   // high half nonzero, R2
      issue(0, 16'h1111, 16'h00FF, 16'h0100, "R2");    wait_idle();   // product fits, flags clear
      issue(0, 16'h0000, 16'h8000, 16'h0002, "R2");    wait_idle();   // carry set again
      issue(1, 16'h0001, 16'h0000, 16'h0010, "R4");    wait_idle();   // R5: flags hold
      issue(1, 16'h0000, 16'd100, 16'd7, "R4");        wait_idle();
      issue(1, 16'h00AB, 16'hCDEF, 16'h0000, "R6");    wait_idle();   // zero divisor, R7
      issue(1, 16'h8000, 16'h0000, 16'h0002, "R8");    wait_idle();   // quotient overflow
      issue(1, 16'hFFFF, 16'hFFFF, 16'h0001, "R8");    wait_idle();

      // R9: stray starts during a run
      issue(0, 16'h0, 16'h1234, 16'h0ABC, "R9");
      repeat (4) begin
         @(negedge clk);
         start = 1; op_div = 1; y_in = 16'h7777; a_in = 16'h5555; src_in = 16'h0;
      end
      @(negedge clk); start = 0;
      wait_idle();

      // R10: new start in the done cycle, back to back
      issue(1, 16'h0003, 16'h0004, 16'h0009, "R4");
      while (!done) @(negedge clk);
      start = 1; op_div = 0; y_in = 0; a_in = 16'hBEEF; src_in = 16'h0101; cur_tag = "R10";
      @(negedge clk); start = 0;
      wait_idle();

      for (int i = 0; i < 40; i++) begin
         logic [15:0] sv;
         rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
         sv = (rs[3:0] == 0) ? 16'h0 : rs[31:16];
         issue(rs[4], rs[15:0], rs[31:16] ^ rs[15:0], sv, rs[4] ? "R4" : "R1");
         wait_idle();
      end

      repeat (3) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule